// File: doc/BRIEF.md
# Second-Order One-Bit Noise Shaper

This block is the front stage of a cascaded digital delta-sigma modulator that drives an oversampled audio DAC. A signed 18-bit PCM sample is taken on each clock where the sample strobe is high. In a typical system the strobe runs at 64 times the audio rate, about 3.07 MHz for a 48 kHz band. Two integrators sit in a loop. The first integrator accumulates the sample minus the fed-back quantizer value. The second integrator adds the first integrator's previous value to its own previous value minus twice the feedback. The sign bit of the second integrator is the one-bit output stream. Its low-pass average follows the input.

The second integrator without its sign bit is sent out as a residue. A later cascade stage uses it to shape this stage's truncation error. All arithmetic is two's complement. A carry or wrap past the register width is discarded.

Top module: `ns2_shaper`

## Requirements
- R1: A synchronous reset clears both integrators and the primed flag. While reset is held and in the cycle after it, `bit_o` is 0 and `resid_o` is 0.
- R2: The first accepted sample after reset uses a feedback value of zero. Its update leaves `bit_o` = 0 and `resid_o` = 0 for any input value.
- R3: After the first sample, the feedback value is +131072 when `bit_o` is 0 and -131072 when `bit_o` is 1. On an accepted sample the first integrator (21 bits, signed) takes the value old + sample − feedback, wrapping modulo 2^21.
- R4: On an accepted sample the second integrator (23 bits, signed) takes the value old first integrator + (old second integrator − 2·feedback). The difference is formed one bit wider and cut back to 23 bits, and the sum wraps modulo 2^23.
- R5: `bit_o` is bit 22 (the sign bit) of the second integrator. `resid_o` is bits 21..0 of the second integrator, so the register equals `resid_o` − `bit_o`·2^22.
- R6: While `smp_en` is low, neither integrator changes, and `bit_o` and `resid_o` hold whatever `smp_in` does.
- R7: For a constant input x, the share of zeros in `bit_o` over N samples is close to N·(1 + x/131072)/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe; one sample accepted per high cycle |
| smp_in | input | 18 | Signed PCM sample |
| bit_o | output | 1 | One-bit shaped output (sign of second integrator) |
| resid_o | output | 22 | Second integrator with the sign bit removed |

## Verification
Both outputs come directly from the second integrator register. A sample accepted at a rising edge therefore shows up on `bit_o` and `resid_o` right after that edge, with no further register in the path. The bench drives each sample on the falling edge. It compares both outputs with its own integer model at the next falling edge, which is exactly one accepted update later. Hold checks sample the outputs at falling edges while the strobe stays low. The density check counts zeros across whole accepted runs, so it does not depend on any cycle alignment.

// File: rtl/ns2_shaper.sv
module ns2_shaper #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_en,
  input  logic [DW-1:0] smp_in,
  output logic          bit_o,
  output logic [DW+3:0] resid_o
);
  localparam int W1 = DW + 3;
  localparam int W2 = DW + 5;
  localparam logic signed [W1-1:0] FS = W1'(1) <<< (DW - 1);

  logic signed [W1-1:0] acc1;
  logic signed [W2-1:0] acc2;
  logic                 primed;

  logic signed [W1-1:0] fb;
  logic signed [W1-1:0] x_ext;
  logic signed [W2:0]   diff;
  logic signed [W2-1:0] clip;
  logic signed [W2-1:0] acc1_ext;

  assign fb       = !primed ? '0 : (acc2[W2-1] ? -FS : FS);
  assign x_ext    = {{(W1-DW){smp_in[DW-1]}}, smp_in};
  assign diff     = {acc2[W2-1], acc2} - {{(W2-W1){fb[W1-1]}}, fb, 1'b0};
  assign clip     = diff[W2-1:0];
  assign acc1_ext = {{(W2-W1){acc1[W1-1]}}, acc1};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc1   <= '0;
      acc2   <= '0;
      primed <= 1'b0;
    end else if (smp_en) begin
      acc1   <= acc1 + x_ext - fb;
      acc2   <= acc1_ext + clip;
      primed <= 1'b1;
    end
  end

  assign bit_o   = acc2[W2-1];
  assign resid_o = acc2[W2-2:0];
endmodule

// File: rtl/ns2_shaper_chk.sv
module ns2_shaper_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_en,
  input logic          primed,
  input logic          bit_o,
  input logic [DW+3:0] resid_o
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!bit_o && resid_o == '0));

  p_first_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (smp_en && !primed) |=> (!bit_o && resid_o == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> ($stable(bit_o) && $stable(resid_o)));

  p_change_src_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(resid_o) |-> $past(smp_en));
endmodule

bind ns2_shaper ns2_shaper_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .smp_en(smp_en), .primed(primed),
  .bit_o(bit_o), .resid_o(resid_o)
);

// File: tb/tb_ns2_shaper.sv
module tb_ns2_shaper;
  localparam int CLK_PERIOD = 10;
  localparam longint FS = 131072;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_en = 1'b0;
  logic [17:0] smp_in = '0;
  logic        bit_o;
  logic [21:0] resid_o;

  int tests = 0;
  int fails = 0;
  longint m1, m2;
  bit     mprimed;

  ns2_shaper dut (.clk(clk), .rst(rst), .smp_en(smp_en), .smp_in(smp_in),
                  .bit_o(bit_o), .resid_o(resid_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic longint wrapw(longint v, int w);
    longint m = (64'sd1 <<< w);
    longint r = v % m;
    if (r < 0) r += m;
    if (r >= m/2) r -= m;
    return r;
  endfunction

  function automatic longint dut_acc2();
    return longint'(resid_o) - (bit_o ? (64'sd1 <<< 22) : 0);
  endfunction

  task automatic model_step(longint x);
    longint fb, c;
    fb = !mprimed ? 0 : ((m2 < 0) ? -FS : FS);
    c  = wrapw(m2 - 2*fb, 23);
    m2 = wrapw(m1 + c, 23);
    m1 = wrapw(m1 + x - fb, 21);
    mprimed = 1'b1;
  endtask

  task automatic check(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(longint x);
    @(negedge clk);
    smp_en = 1'b1;
    smp_in = 18'(x);
    model_step(x);
    @(negedge clk);
    smp_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    smp_en = 1'b1;
    smp_in = 18'h1ABCD;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    smp_en = 1'b0;
    m1 = 0; m2 = 0; mprimed = 1'b0;
    check("R1 bit after reset", bit_o, 0);
    check("R1 residue after reset", resid_o, 0);
  endtask

  task automatic t_first();
    do_reset();
    push(-100000);
    check("R2 first sample bit", bit_o, 0);
    check("R2 first sample residue", resid_o, 0);
  endtask

  task automatic t_track(string tag, int n, int kind);
    int bad = 0;
    longint x;
    for (int i = 0; i < n; i++) begin
      case (kind)
        0: x = 5000;
        1: x = -70000;
        2: x = ((i % 32) < 16) ? 60000 : -60000;
        default: x = ((i * 7919) % 180001) - 90000;
      endcase
      push(x);
      if (dut_acc2() != m2 || bit_o != (m2 < 0)) begin
        if (bad == 0) check({tag, " R3 R4 R5 integrator state"}, dut_acc2(), m2);
        bad++;
      end
    end
    if (bad == 0) check({tag, " R3 R4 R5 integrator state"}, dut_acc2(), m2);
  endtask

  task automatic t_hold();
    longint r0 = resid_o;
    logic   b0 = bit_o;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      smp_en = 1'b0;
      smp_in = 18'(i * 33333);
    end
    @(negedge clk);
    check("R6 residue held", resid_o, r0);
    check("R6 bit held", bit_o, b0);
    push(1234);
    check("R6 state resumes after hold", dut_acc2(), m2);
  endtask

  task automatic t_density(longint x, int n);
    int zeros = 0;
    longint exp_z;
    do_reset();
    for (int i = 0; i < n; i++) begin
      push(x);
      if (!bit_o) zeros++;
    end
    exp_z = (longint'(n) * (FS + x)) / (2 * FS);
    tests++;
    if (zeros < exp_z - 32 || zeros > exp_z + 32) begin
      fails++;
      $display("FAIL R7 density: got %0d zeros expected about %0d", zeros, exp_z);
    end
  endtask

  initial begin
    m1 = 0; m2 = 0; mprimed = 1'b0;
    repeat (3) @(negedge clk);
    do_reset();
    t_first();
    t_track("dc-small", 200, 0);
    t_track("dc-neg", 200, 1);
    t_hold();
    t_track("square", 400, 2);
    do_reset();
    t_track("ramp", 600, 3);
    t_density(65536, 4096);
    t_density(-49152, 4096);
    t_density(0, 2048);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule